// File: doc/BRIEF.md
# Thread Continuation Queue Scheduler

This block chooses the fetch program counter for a pipeline that runs many threads of one shared context. A thread has no state except its program counter, so a thread switch saves and restores nothing. The block stores the ready program counters in a FIFO. The pipeline front end reports, in the same cycle, the kind of instruction found at the current fetch PC. After an ordinary instruction the same thread carries on in sequence. After an instruction whose outcome is not known in advance, the next fetch comes from the oldest queued PC. No prediction is made and nothing is flushed.

A create instruction adds its target address to the queue, and its own thread carries on at the next sequential address. A kill ends the current thread. The register stage can return a PC to the queue in two ways: a requeue when an operand turned out to be ready, and a wake-up when a suspended thread is released. After reset there is one thread, and it starts at the boot address. If the queue has no PC when a switch is needed, the fetch valid flag drops and the block issues bubbles until a PC arrives.

Top module: `tcq_sched`

## Requirements
- R1: While reset is high and in the first cycle after it, fetch_valid is 1, fetch_pc equals boot_pc, create_stall is 0, queue_empty is 1 and queue_full is 0.
- R2: With fetch_valid high and ev_kind = 0 (sequential), the next cycle fetches fetch_pc + STEP from the same thread.
- R3: With fetch_valid high and ev_kind = 1 (create), if a slot is free the create_target enters the queue tail and the next fetch_pc is fetch_pc + STEP.
- R4: With fetch_valid high and ev_kind = 2 (switch), the next fetch_pc is the oldest queued PC and that PC leaves the queue. The switching thread's PC is not queued by this block.
- R5: With fetch_valid high and ev_kind = 3 (kill), the next fetch_pc is taken from the queue head as in R4, and the killed PC is never fetched again unless it is pushed again.
- R6: A switch or kill that finds the queue empty makes fetch_valid 0 in the next cycle. fetch_valid stays 0 until a PC is stored. A PC pushed during a bubble cycle t is fetched with fetch_valid 1 in cycle t+2.
- R7: Pushes in the same cycle enter the queue in this order: requeue, then wake-up, then create. Each one needs a slot that is left after that cycle's pop. A requeue or wake-up that finds no slot is discarded.
- R8: A create that finds no free slot does not enqueue its target. In the next cycle fetch_pc is unchanged, fetch_valid stays 1 and create_stall is 1, so the create is issued again.
- R9: While fetch_valid is 0, ev_kind and create_target have no effect: nothing is pushed by them and create_stall stays 0.
- R10: queue_empty is 1 exactly when no PC is stored, and queue_full is 1 exactly when DEPTH PCs are stored.
- R11: PCs leave the queue in the order in which they entered it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; empties the queue and restarts at boot_pc |
| boot_pc | input | AW | Address of the single thread that exists after reset |
| ev_kind | input | 2 | Kind of the instruction at fetch_pc: 0 sequential, 1 create, 2 switch, 3 kill |
| create_target | input | AW | Target address of a create instruction |
| rq_valid | input | 1 | Register stage returns a ready thread to the queue |
| rq_pc | input | AW | PC of the requeued thread |
| wake_valid | input | 1 | Register stage wakes a suspended thread |
| wake_pc | input | AW | PC of the woken thread |
| fetch_pc | output | AW | PC to fetch this cycle |
| fetch_valid | output | 1 | fetch_pc is a real fetch; 0 marks a bubble |
| create_stall | output | 1 | This fetch repeats a create that found the queue full |
| queue_full | output | 1 | DEPTH PCs are stored |
| queue_empty | output | 1 | No PC is stored |

## Verification
Short directed sequences drive the block one event kind at a time. A run of sequential instructions shows that the PC steps in place. Creates followed by switches show that stored PCs come back in FIFO order. A kill followed by a switch shows that the killed PC does not return. A cycle that carries all three pushes sets requeue-before-wake-before-create apart from other possible orderings. A switch on an empty queue, with create events driven during the bubble, shows both the bubble and that events are ignored while no fetch is valid. Filling a small queue and then creating into it brings out the stall and the retry. A long stretch of mixed events is then compared against a queue model in the bench, so that counting, wrap-around of the pointers and overlapping pop/push cycles are all covered.

// File: rtl/tcq_pkg.sv
package tcq_pkg;

  // Kind of the instruction sitting at the current fetch PC.
  typedef enum logic [1:0] {
    EV_SEQ    = 2'd0,
    EV_CREATE = 2'd1,
    EV_SWITCH = 2'd2,
    EV_KILL   = 2'd3
  } ev_kind_e;

  // Push sources, in the order they enter the queue within one cycle.
  localparam int NPUSH    = 3;
  localparam int PUSH_RQ  = 0;
  localparam int PUSH_WK  = 1;
  localparam int PUSH_CR  = 2;

endpackage

// File: rtl/tcq_fifo.sv
module tcq_fifo
  import tcq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NPUSH-1:0]          push_vld,
  input  logic [NPUSH-1:0][AW-1:0]  push_pc,
  input  logic                      pop,
  output logic [AW-1:0]             head_pc,
  output logic [CW-1:0]             count
);

  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] head_q;
  logic [PW-1:0] tail_q;
  logic [CW-1:0] count_q;
  logic [PW-1:0] slot [NPUSH];
  logic [PW-1:0] tail_nxt;
  logic          pop_ok;

  assign pop_ok = pop && (count_q != '0);

  // Pack the valid pushes into consecutive slots, lowest source first.
  always_comb begin
    logic [PW-1:0] run;
    run = tail_q;
    for (int i = 0; i < NPUSH; i++) begin
      slot[i] = run;
      if (push_vld[i]) run = run + PW'(1);
    end
    tail_nxt = run;
  end

  // One write port per push source; the slots never collide.
  for (genvar g = 0; g < NPUSH; g++) begin : g_wr
    always_ff @(posedge clk) begin
      if (push_vld[g]) mem[slot[g]] <= push_pc[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      tail_q  <= tail_nxt;
      if (pop_ok) head_q <= head_q + PW'(1);
      count_q <= count_q + CW'($countones(push_vld)) - CW'(pop_ok);
    end
  end

  assign head_pc = mem[head_q];
  assign count   = count_q;

endmodule

// File: rtl/tcq_pcsel.sv
module tcq_pcsel
  import tcq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int STEP  = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [AW-1:0]             boot_pc,
  input  ev_kind_e                  ev,
  input  logic [AW-1:0]             create_target,
  input  logic                      rq_vld,
  input  logic [AW-1:0]             rq_pc,
  input  logic                      wk_vld,
  input  logic [AW-1:0]             wk_pc,
  input  logic [AW-1:0]             head_pc,
  input  logic [CW-1:0]             count,
  output logic [NPUSH-1:0]          push_vld,
  output logic [NPUSH-1:0][AW-1:0]  push_pc,
  output logic                      pop,
  output logic [AW-1:0]             fetch_pc,
  output logic                      fetch_valid,
  output logic                      create_stall
);

  logic want_pop, rq_ok, wk_ok, cr_want, cr_ok;
  int   room;

  always_comb begin
    // A bubble always tries to refill; a valid fetch pops on switch or kill.
    want_pop = fetch_valid ? (ev == EV_SWITCH || ev == EV_KILL) : 1'b1;
    pop      = want_pop && (count != '0);
    room     = DEPTH - int'(count) + int'(pop);
    rq_ok    = rq_vld && (room >= 1);
    wk_ok    = wk_vld && (room >= 1 + int'(rq_ok));
    cr_want  = fetch_valid && (ev == EV_CREATE);
    cr_ok    = cr_want && (room >= 1 + int'(rq_ok) + int'(wk_ok));
    push_vld = '0;
    push_vld[PUSH_RQ] = rq_ok;
    push_vld[PUSH_WK] = wk_ok;
    push_vld[PUSH_CR] = cr_ok;
    push_pc[PUSH_RQ]  = rq_pc;
    push_pc[PUSH_WK]  = wk_pc;
    push_pc[PUSH_CR]  = create_target;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fetch_pc     <= boot_pc;
      fetch_valid  <= 1'b1;
      create_stall <= 1'b0;
    end else begin
      create_stall <= cr_want && !cr_ok;
      if (fetch_valid) begin
        unique case (ev)
          EV_SEQ:    fetch_pc <= fetch_pc + AW'(STEP);
          EV_CREATE: if (cr_ok) fetch_pc <= fetch_pc + AW'(STEP);
          EV_SWITCH, EV_KILL: begin
            if (pop) fetch_pc <= head_pc;
            else     fetch_valid <= 1'b0;
          end
          default: fetch_pc <= fetch_pc;
        endcase
      end else if (pop) begin
        fetch_pc    <= head_pc;
        fetch_valid <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/tcq_sched.sv
module tcq_sched
  import tcq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int STEP  = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] boot_pc,
  input  logic [1:0]    ev_kind,
  input  logic [AW-1:0] create_target,
  input  logic          rq_valid,
  input  logic [AW-1:0] rq_pc,
  input  logic          wake_valid,
  input  logic [AW-1:0] wake_pc,
  output logic [AW-1:0] fetch_pc,
  output logic          fetch_valid,
  output logic          create_stall,
  output logic          queue_full,
  output logic          queue_empty
);

  logic [NPUSH-1:0]         push_vld;
  logic [NPUSH-1:0][AW-1:0] push_pc;
  logic                     pop;
  logic [AW-1:0]            head_pc;
  logic [CW-1:0]            count;
  ev_kind_e                 ev;

  assign ev = ev_kind_e'(ev_kind);

  tcq_pcsel #(.DEPTH(DEPTH), .AW(AW), .STEP(STEP)) u_sel (
    .clk(clk), .rst(rst), .boot_pc(boot_pc), .ev(ev),
    .create_target(create_target),
    .rq_vld(rq_valid), .rq_pc(rq_pc),
    .wk_vld(wake_valid), .wk_pc(wake_pc),
    .head_pc(head_pc), .count(count),
    .push_vld(push_vld), .push_pc(push_pc), .pop(pop),
    .fetch_pc(fetch_pc), .fetch_valid(fetch_valid),
    .create_stall(create_stall)
  );

  tcq_fifo #(.DEPTH(DEPTH), .AW(AW)) u_q (
    .clk(clk), .rst(rst),
    .push_vld(push_vld), .push_pc(push_pc), .pop(pop),
    .head_pc(head_pc), .count(count)
  );

  assign queue_empty = (count == '0);
  assign queue_full  = (count == CW'(DEPTH));

endmodule

// File: rtl/tcq_sched_chk.sv
module tcq_sched_chk #(
  parameter int AW   = 32,
  parameter int STEP = 4
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    ev_kind,
  input logic [AW-1:0] fetch_pc,
  input logic          fetch_valid,
  input logic          create_stall,
  input logic          queue_full,
  input logic          queue_empty
);

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && ev_kind == 2'd0) |=>
      (fetch_valid && fetch_pc == $past(fetch_pc) + AW'(STEP)));

  assert_create_step_R3: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && ev_kind == 2'd1) |=>
      (fetch_valid && (create_stall ? (fetch_pc == $past(fetch_pc))
                                    : (fetch_pc == $past(fetch_pc) + AW'(STEP)))));

  assert_switch_refill_R4: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && ev_kind[1] && !queue_empty) |=> fetch_valid);

  assert_bubble_R6: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && ev_kind[1] && queue_empty) |=> !fetch_valid);

  assert_full_stall_R8: assert property (@(posedge clk) disable iff (rst)
    (fetch_valid && ev_kind == 2'd1 && queue_full) |=> create_stall);

  assert_stall_valid_R8: assert property (@(posedge clk) disable iff (rst)
    create_stall |-> fetch_valid);

  assert_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (!fetch_valid && queue_empty) |=> (!fetch_valid && !create_stall));

  assert_full_empty_R10: assert property (@(posedge clk) disable iff (rst)
    !(queue_full && queue_empty));

endmodule

bind tcq_sched tcq_sched_chk #(.AW(AW), .STEP(STEP)) u_chk (
  .clk(clk), .rst(rst), .ev_kind(ev_kind), .fetch_pc(fetch_pc),
  .fetch_valid(fetch_valid), .create_stall(create_stall),
  .queue_full(queue_full), .queue_empty(queue_empty)
);

// File: tb/tcq_sched_test.sv
module tcq_sched_test;

  localparam int PERIOD = 10;
  localparam int DEPTH  = 4;
  localparam int AW     = 32;
  localparam int STEP   = 4;
  localparam logic [AW-1:0] BOOT = 32'h0000_0100;

  logic          clk = 1'b0;
  logic          rst;
  logic [1:0]    ev_kind;
  logic [AW-1:0] create_target, rq_pc, wake_pc;
  logic          rq_valid, wake_valid;
  logic [AW-1:0] fetch_pc;
  logic          fetch_valid, create_stall, queue_full, queue_empty;

  always #(PERIOD/2) clk = ~clk;

  tcq_sched #(.DEPTH(DEPTH), .AW(AW), .STEP(STEP)) uut (
    .clk(clk), .rst(rst), .boot_pc(BOOT), .ev_kind(ev_kind),
    .create_target(create_target), .rq_valid(rq_valid), .rq_pc(rq_pc),
    .wake_valid(wake_valid), .wake_pc(wake_pc),
    .fetch_pc(fetch_pc), .fetch_valid(fetch_valid),
    .create_stall(create_stall), .queue_full(queue_full),
    .queue_empty(queue_empty)
  );

  typedef struct {
    logic          valid;
    logic [AW-1:0] pc;
    logic          stall;
    logic          empty;
    logic          full;
    string         tag;
  } exp_t;

  exp_t          sb[$];
  logic [AW-1:0] mq[$];
  logic [AW-1:0] m_pc;
  logic          m_valid;
  int            n_chk = 0;
  int            n_bad = 0;
  bit            done  = 0;

  task automatic compare(input exp_t e);
    bit ok;
    n_chk++;
    ok = (fetch_valid === e.valid) && (!e.valid || fetch_pc === e.pc) &&
         (create_stall === e.stall) && (queue_empty === e.empty) &&
         (queue_full === e.full);
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got v=%0b pc=%h st=%0b e=%0b f=%0b exp v=%0b pc=%h st=%0b e=%0b f=%0b",
               e.tag, fetch_valid, fetch_pc, create_stall, queue_empty, queue_full,
               e.valid, e.pc, e.stall, e.empty, e.full);
    end
  endtask

  // Monitor: compares one expected item a quarter period after each edge.
  initial begin
    forever begin
      @(posedge clk);
      #(PERIOD/4);
      if (sb.size() > 0) compare(sb.pop_front());
    end
  end

  // Driver: computes the expected next state from the requirements, then drives.
  task automatic step(input logic [1:0] k, input logic [AW-1:0] tgt,
                      input logic rq, input logic [AW-1:0] rqp,
                      input logic wk, input logic [AW-1:0] wkp,
                      input string tag);
    int sz, room;
    bit pop, rq_ok, wk_ok, cr_want, cr_ok;
    logic [AW-1:0] head;
    exp_t e;
    sz      = mq.size();
    pop     = (m_valid ? (k == 2'd2 || k == 2'd3) : 1'b1) && (sz > 0);
    head    = (sz > 0) ? mq[0] : '0;
    room    = DEPTH - sz + int'(pop);
    rq_ok   = rq && (room >= 1);
    wk_ok   = wk && (room >= 1 + int'(rq_ok));
    cr_want = m_valid && (k == 2'd1);
    cr_ok   = cr_want && (room >= 1 + int'(rq_ok) + int'(wk_ok));
    if (pop)   void'(mq.pop_front());
    if (rq_ok) mq.push_back(rqp);
    if (wk_ok) mq.push_back(wkp);
    if (cr_ok) mq.push_back(tgt);
    if (m_valid) begin
      case (k)
        2'd0: m_pc = m_pc + STEP;
        2'd1: if (cr_ok) m_pc = m_pc + STEP;
        default: if (pop) m_pc = head; else m_valid = 1'b0;
      endcase
    end else if (pop) begin
      m_pc = head; m_valid = 1'b1;
    end
    e.valid = m_valid; e.pc = m_pc; e.stall = cr_want && !cr_ok;
    e.empty = (mq.size() == 0); e.full = (mq.size() == DEPTH); e.tag = tag;
    sb.push_back(e);
    ev_kind = k; create_target = tgt;
    rq_valid = rq; rq_pc = rqp; wake_valid = wk; wake_pc = wkp;
    @(negedge clk);
  endtask

  task automatic seq(input string tag);  step(2'd0, '0, 0, '0, 0, '0, tag); endtask
  task automatic crt(input logic [AW-1:0] t, input string tag); step(2'd1, t, 0, '0, 0, '0, tag); endtask
  task automatic swi(input string tag);  step(2'd2, '0, 0, '0, 0, '0, tag); endtask
  task automatic kil(input string tag);  step(2'd3, '0, 0, '0, 0, '0, tag); endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    exp_t r;
    rst = 1'b1; ev_kind = 2'd0; create_target = '0;
    rq_valid = 0; rq_pc = '0; wake_valid = 0; wake_pc = '0;
    m_pc = BOOT; m_valid = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state visible while reset is held
    r.valid = 1; r.pc = BOOT; r.stall = 0; r.empty = 1; r.full = 0; r.tag = "R1";
    compare(r);
    rst = 1'b0;

    seq("R2"); seq("R2"); seq("R2");
    crt(32'h200, "R3"); crt(32'h300, "R3"); seq("R2");
    swi("R4");                 // fetch 0x200
    seq("R2");
    kil("R5");                 // fetch 0x300, 0x200 thread gone
    swi("R6");                 // queue empty: bubble
    crt(32'h900, "R9");        // ignored during bubble
    step(2'd1, 32'h904, 1, 32'h400, 0, '0, "R6");  // requeue during bubble
    seq("R6"); seq("R6");       // 0x400 fetched
    // R7: all three pushes in one cycle
    step(2'd1, 32'hA00, 1, 32'hB00, 1, 32'hC00, "R7");
    swi("R7"); swi("R7"); swi("R7");   // B00, C00, A00 in order
    swi("R6");
    seq("R9"); seq("R9");
    step(2'd0, '0, 0, '0, 1, 32'h500, "R6");
    seq("R6"); seq("R6");
    // R10/R8: fill then create into a full queue
    crt(32'h610, "R10"); crt(32'h620, "R10"); crt(32'h630, "R10"); crt(32'h640, "R10");
    crt(32'h650, "R8"); crt(32'h650, "R8");
    step(2'd0, '0, 1, 32'h660, 0, '0, "R7");   // requeue dropped: no slot
    swi("R11"); crt(32'h670, "R8"); swi("R11"); swi("R11"); swi("R11");
    swi("R11"); swi("R11");

    for (int i = 0; i < 400; i++) begin
      step(2'($urandom % 4), ($urandom & 32'hFFFC),
           ($urandom % 4 == 0), ($urandom & 32'hFFFC),
           ($urandom % 5 == 0), ($urandom & 32'hFFFC), "R11");
    end
    seq("R2");
    repeat (2) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule